// File: doc/BRIEF.md
# HDLC Transmit Framer with Modem Control

This block turns bytes held in a small internal transmit queue into a synchronous serial HDLC bit stream, one bit per clock. Each frame is built from the opening flag, the queued payload with zero bits inserted after runs of ones, an optional 16-bit frame check sequence, and the closing flag. When no frame is ready the line carries continuous ones. Each frame can be preceded by a programmable preamble byte that is repeated a set number of times.

The write side is a simple valid/data/last interface with a full indication. The bit order of payload bytes can be selected. Modem control covers three things. A data-terminal-ready output follows a control bit. A clear-to-send input pauses the transmitter. An auto mode makes a deasserted clear-to-send also empty the queue and return the transmitter to idle. Control inputs are expected to be set by a register bank outside the block.

Top module: `hdlc_tx_framer`

## Requirements
- R1: During and after reset, `txd` is 1 and `dtr_n` is 1. Whenever no frame is being sent, `txd` stays at 1 (mark idle).
- R2: A frame starts one clock after the transmitter finds a queued byte while active. It sends the flag 0x7E, then the queued bytes up to and including the one written with `wr_last`=1, then the optional check sequence, then 0x7E again, with no gap between bits. Consecutive frames are separated by at least one idle 1.
- R3: Inside payload and check-sequence bits, a 0 is inserted after every run of five consecutive 1s. A run that ends the payload or check sequence is still followed by its inserted 0 before the closing flag. Flags and preamble are never stuffed.
- R4: The check sequence is the reflected CRC-16-CCITT (polynomial 0x8408 in reflected form, start value 0xFFFF) over the payload bits in line order. It is sent complemented, bit 0 first, so the low byte goes out first.
- R5: With `no_crc`=1 at frame start, no check sequence is sent, and the closing flag follows the last payload bit (after any inserted 0).
- R6: With `msb_first`=0 each payload byte is sent bit 0 first. With `msb_first`=1 it is sent bit 7 first. The check sequence order does not change.
- R7: With `pre_en`=1 at frame start, `pre_pattern` is sent `pre_count` times, in the selected bit order, directly before the opening flag. A count of 0 sends no preamble.
- R8: `dtr_n` is the inverse of `dtr_on`, registered with one clock of delay.
- R9: While `tx_en`=1, `cts_n`=1 and `auto_en`=0, `txd` is 1 and the transmitter holds its position. Queued data is kept, and the frame resumes where it stopped once `cts_n` returns to 0.
- R10: While `tx_en`=1, `cts_n`=1 and `auto_en`=1, `txd` is 1, the queue is emptied and the transmitter returns to idle. Any partly sent frame and any queued frames are dropped.
- R11: While `tx_en`=0, `cts_n` has no effect. The transmitter holds, sends ones, and keeps the queue, even with `auto_en`=1.
- R12: The queue holds `FIFO_DEPTH` entries. `wr_full` is 1 when it holds that many, and a write presented while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; gates all activity and the clear-to-send input |
| cts_n | input | 1 | Clear-to-send, active low |
| auto_en | input | 1 | 1: deasserted clear-to-send flushes queue and transmitter |
| dtr_on | input | 1 | Data-terminal-ready request |
| pre_en | input | 1 | Send preamble before each frame |
| no_crc | input | 1 | Suppress the check sequence |
| msb_first | input | 1 | Payload and preamble bit order, 1 = bit 7 first |
| pre_pattern | input | 8 | Preamble byte |
| pre_count | input | PCNT_W | Number of preamble repetitions |
| wr_valid | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Payload byte |
| wr_last | input | 1 | Marks the final byte of a frame |
| wr_full | output | 1 | Queue holds FIFO_DEPTH entries |
| txd | output | 1 | Serial line output |
| dtr_n | output | 1 | Data-terminal-ready, active low |

## Verification
The bench builds the block with its defaults: a 16-entry queue and a 4-bit preamble count. With these values the full boundary is reached by a single 16-byte frame, so both the drop of a seventeenth write and the correct draining of a full queue can be observed. A 4-bit count allows several preamble repetitions, and the zero-count case, to be tested within short runs. Payload bytes made of long runs of ones, including a byte that ends on five ones, are used for stuffing. The check sequence is tested in both bit orders, and pauses and flushes are placed in the middle of a frame.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam logic [7:0]  HDLC_FLAG  = 8'h7E;
  localparam logic [15:0] FCS_SEED   = 16'hFFFF;
  localparam logic [15:0] FCS_POLY_R = 16'h8408;
  localparam int          STUFF_RUN  = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_OPEN,
    S_DATA,
    S_WAIT,
    S_FCS,
    S_CLOSE
  } tx_state_t;

  // one step of the reflected CCITT CRC for a single line bit
  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic b);
    fcs_step = (c >> 1) ^ ((c[0] ^ b) ? FCS_POLY_R : 16'h0000);
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
// Byte queue with registered read; DEPTH must be a power of two.
module hdlc_tx_fifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_pop,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, rp_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          do_wr, do_rd;

  assign do_wr  = wr_en && !full && !flush;
  assign do_rd  = rd_pop && rd_valid && !flush;
  assign rp_nxt = do_rd ? rp + AW'(1) : rp;

  always_comb begin
    cnt_nxt = cnt;
    if (do_wr && !do_rd)      cnt_nxt = cnt + CW'(1);
    else if (!do_wr && do_rd) cnt_nxt = cnt - CW'(1);
  end

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
    rd_data <= mem[rp_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      full     <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (do_wr) wp <= wp + AW'(1);
      rp       <= rp_nxt;
      cnt      <= cnt_nxt;
      full     <= (cnt_nxt == CW'(DEPTH));
      // only entries already in memory before this edge are readable
      rd_valid <= ((cnt - CW'(do_rd)) != '0);
    end
  end

endmodule

// File: rtl/hdlc_tx_modem.sv
module hdlc_tx_modem (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic cts_n,
  input  logic auto_en,
  input  logic dtr_on,
  output logic hold,
  output logic flush,
  output logic dtr_n
);
  assign hold  = !tx_en || cts_n;
  assign flush = tx_en && cts_n && auto_en;

  always_ff @(posedge clk) begin
    if (rst) dtr_n <= 1'b1;
    else     dtr_n <= !dtr_on;
  end
endmodule

// File: rtl/hdlc_tx_serial.sv
module hdlc_tx_serial
  import hdlc_tx_pkg::*;
#(
  parameter int PCW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           clear,
  input  logic           msb_first,
  input  logic           no_crc,
  input  logic           pre_en,
  input  logic [7:0]     pre_pattern,
  input  logic [PCW-1:0] pre_count,
  input  logic           fifo_valid,
  input  logic [7:0]     fifo_data,
  input  logic           fifo_last,
  output logic           fifo_pop,
  output logic           txd
);
  tx_state_t      state, st_n;
  logic [15:0]    sh, sh_n, fcs, fcs_n;
  logic [3:0]     idx, idx_n;
  logic [2:0]     ones, ones_n;
  logic [PCW-1:0] reps, reps_n;
  logic [7:0]     pat_q, pat_n, load_val;
  logic           last_q, last_n, msb_q, msb_n, nocrc_q, nocrc_n;
  logic           bit_o, pop, stuff;

  always_comb begin
    st_n     = state;
    sh_n     = sh;
    fcs_n    = fcs;
    idx_n    = idx;
    ones_n   = ones;
    reps_n   = reps;
    pat_n    = pat_q;
    last_n   = last_q;
    msb_n    = msb_q;
    nocrc_n  = nocrc_q;
    bit_o    = 1'b1;
    pop      = 1'b0;
    load_val = msb_q ? rev8(fifo_data) : fifo_data;
    stuff    = (ones == 3'(STUFF_RUN));
    unique case (state)
      S_IDLE: begin
        if (fifo_valid) begin
          msb_n   = msb_first;
          nocrc_n = no_crc;
          pat_n   = msb_first ? rev8(pre_pattern) : pre_pattern;
          idx_n   = '0;
          ones_n  = '0;
          fcs_n   = FCS_SEED;
          if (pre_en && pre_count != '0) begin
            st_n   = S_PRE;
            reps_n = pre_count;
          end else begin
            st_n   = S_OPEN;
          end
        end
      end
      S_PRE: begin
        bit_o = pat_q[idx[2:0]];
        idx_n = idx + 4'd1;
        if (idx == 4'd7) begin
          idx_n = '0;
          if (reps == PCW'(1)) st_n = S_OPEN;
          else                 reps_n = reps - PCW'(1);
        end
      end
      S_OPEN: begin
        bit_o = HDLC_FLAG[idx[2:0]];
        idx_n = idx + 4'd1;
        if (idx == 4'd7) begin
          idx_n  = '0;
          st_n   = S_DATA;
          pop    = 1'b1;
          sh_n   = {8'h00, load_val};
          last_n = fifo_last;
        end
      end
      S_DATA, S_FCS: begin
        if (stuff) begin
          bit_o  = 1'b0;
          ones_n = '0;
        end else begin
          bit_o  = sh[0];
          sh_n   = sh >> 1;
          ones_n = sh[0] ? ones + 3'd1 : 3'd0;
          idx_n  = idx + 4'd1;
          if (state == S_DATA) begin
            fcs_n = fcs_step(fcs, sh[0]);
            if (idx == 4'd7) begin
              idx_n = '0;
              if (last_q) begin
                if (nocrc_q) begin
                  st_n = S_CLOSE;
                end else begin
                  st_n = S_FCS;
                  sh_n = ~fcs_step(fcs, sh[0]);
                end
              end else if (fifo_valid) begin
                pop    = 1'b1;
                sh_n   = {8'h00, load_val};
                last_n = fifo_last;
              end else begin
                st_n = S_WAIT;
              end
            end
          end else if (idx == 4'd15) begin
            idx_n = '0;
            st_n  = S_CLOSE;
          end
        end
      end
      S_WAIT: begin
        if (fifo_valid) begin
          pop    = 1'b1;
          sh_n   = {8'h00, load_val};
          last_n = fifo_last;
          st_n   = S_DATA;
        end
      end
      S_CLOSE: begin
        if (idx == 4'd0 && stuff) begin
          bit_o  = 1'b0;
          ones_n = '0;
        end else begin
          bit_o = HDLC_FLAG[idx[2:0]];
          idx_n = idx + 4'd1;
          if (idx == 4'd7) begin
            idx_n  = '0;
            ones_n = '0;
            st_n   = S_IDLE;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  assign fifo_pop = pop && !hold && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state   <= S_IDLE;
      sh      <= '0;
      fcs     <= FCS_SEED;
      idx     <= '0;
      ones    <= '0;
      reps    <= '0;
      pat_q   <= '0;
      last_q  <= 1'b0;
      msb_q   <= 1'b0;
      nocrc_q <= 1'b0;
      txd     <= 1'b1;
    end else if (hold) begin
      txd     <= 1'b1;
    end else begin
      state   <= st_n;
      sh      <= sh_n;
      fcs     <= fcs_n;
      idx     <= idx_n;
      ones    <= ones_n;
      reps    <= reps_n;
      pat_q   <= pat_n;
      last_q  <= last_n;
      msb_q   <= msb_n;
      nocrc_q <= nocrc_n;
      txd     <= bit_o;
    end
  end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int FIFO_DEPTH = 16,
  parameter int PCNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic              auto_en,
  input  logic              dtr_on,
  input  logic              pre_en,
  input  logic              no_crc,
  input  logic              msb_first,
  input  logic [7:0]        pre_pattern,
  input  logic [PCNT_W-1:0] pre_count,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              wr_last,
  output logic              wr_full,
  output logic              txd,
  output logic              dtr_n
);
  localparam int QW = 9;

  logic          hold, flush, pop, q_valid;
  logic [QW-1:0] q_data;

  hdlc_tx_modem u_modem (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .cts_n   (cts_n),
    .auto_en (auto_en),
    .dtr_on  (dtr_on),
    .hold    (hold),
    .flush   (flush),
    .dtr_n   (dtr_n)
  );

  hdlc_tx_fifo #(.DW(QW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .wr_en    (wr_valid),
    .wr_data  ({wr_last, wr_data}),
    .full     (wr_full),
    .rd_pop   (pop),
    .rd_valid (q_valid),
    .rd_data  (q_data)
  );

  hdlc_tx_serial #(.PCW(PCNT_W)) u_ser (
    .clk         (clk),
    .rst         (rst),
    .hold        (hold),
    .clear       (flush),
    .msb_first   (msb_first),
    .no_crc      (no_crc),
    .pre_en      (pre_en),
    .pre_pattern (pre_pattern),
    .pre_count   (pre_count),
    .fifo_valid  (q_valid),
    .fifo_data   (q_data[7:0]),
    .fifo_last   (q_data[8]),
    .fifo_pop    (pop),
    .txd         (txd)
  );

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic cts_n,
  input logic auto_en,
  input logic dtr_on,
  input logic wr_full,
  input logic txd,
  input logic dtr_n
);
  // R1
  a_r1_reset_mark: assert property (@(posedge clk) rst |=> (txd && dtr_n));

  // R8
  a_r8_dtr_asserted: assert property (@(posedge clk) disable iff (rst)
    dtr_on |=> !dtr_n);
  a_r8_dtr_released: assert property (@(posedge clk) disable iff (rst)
    !dtr_on |=> dtr_n);

  // R9
  a_r9_hold_mark: assert property (@(posedge clk) disable iff (rst)
    (tx_en && cts_n) |=> txd);

  // R10
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
    (tx_en && cts_n && auto_en) |=> (!wr_full && txd));

  // R11
  a_r11_disabled_mark: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> txd);

  // R12
  a_r12_full_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_full && !tx_en) |=> wr_full);
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_en   (tx_en),
  .cts_n   (cts_n),
  .auto_en (auto_en),
  .dtr_on  (dtr_on),
  .wr_full (wr_full),
  .txd     (txd),
  .dtr_n   (dtr_n)
);

// File: tb/sim_hdlc_tx_framer.sv
`timescale 1ns/1ps
module sim_hdlc_tx_framer;
  localparam int DEPTH = 16;
  localparam int PCW   = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, tx_en = 1'b0, cts_n = 1'b0, auto_en = 1'b0, dtr_on = 1'b0;
  logic pre_en = 1'b0, no_crc = 1'b0, msb_first = 1'b0;
  logic [7:0] pre_pattern = 8'h00;
  logic [PCW-1:0] pre_count = '0;
  logic wr_valid = 1'b0, wr_last = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_full, txd, dtr_n;

  hdlc_tx_framer #(.FIFO_DEPTH(DEPTH), .PCNT_W(PCW)) u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .cts_n(cts_n), .auto_en(auto_en),
    .dtr_on(dtr_on), .pre_en(pre_en), .no_crc(no_crc), .msb_first(msb_first),
    .pre_pattern(pre_pattern), .pre_count(pre_count), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_last(wr_last), .wr_full(wr_full), .txd(txd), .dtr_n(dtr_n)
  );

  int total = 0, bad = 0, cyc_n = 0;
  bit finished = 0, cmp_on = 0;
  string tag = "R1";

  logic [8:0] mq[$];
  bit         pend[$];
  logic       exp_txd = 1'b1, exp_dtr = 1'b1;

  task automatic chk(input string rq, input logic act, input logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", rq, act, expv, $time);
    end
  endtask

  function automatic logic [15:0] fcs16(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[k]) begin
      c ^= {8'h00, q[k]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build_frame();
    logic [7:0] sent[$];
    bit body[$];
    logic [8:0] e;
    logic [7:0] v;
    logic [15:0] f;
    int run = 0;
    if (pre_en)
      for (int r = 0; r < int'(pre_count); r++)
        for (int i = 0; i < 8; i++) pend.push_back(msb_first ? pre_pattern[7-i] : pre_pattern[i]);
    for (int i = 0; i < 8; i++) pend.push_back((i != 0) && (i != 7));
    do begin
      e = mq.pop_front();
      for (int i = 0; i < 8; i++) v[i] = msb_first ? e[7-i] : e[i];
      sent.push_back(v);
      for (int i = 0; i < 8; i++) body.push_back(v[i]);
    end while (!e[8] && mq.size() > 0);
    if (!no_crc) begin
      f = fcs16(sent);
      for (int i = 0; i < 16; i++) body.push_back(f[i]);
    end
    foreach (body[k]) begin
      pend.push_back(body[k]);
      run = body[k] ? run + 1 : 0;
      if (run == 5) begin pend.push_back(1'b0); run = 0; end
    end
    for (int i = 0; i < 8; i++) pend.push_back((i != 0) && (i != 7));
  endtask

  // behavioural reference, stepped on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); pend.delete(); exp_txd = 1'b1; exp_dtr = 1'b1;
    end else begin
      exp_dtr = !dtr_on;
      if (tx_en && cts_n && auto_en) begin
        mq.delete(); pend.delete(); exp_txd = 1'b1;
      end else begin
        if (!tx_en || cts_n)        exp_txd = 1'b1;
        else if (pend.size() > 0)   exp_txd = pend.pop_front();
        else if (mq.size() > 0)     begin build_frame(); exp_txd = 1'b1; end
        else                        exp_txd = 1'b1;
        if (wr_valid && mq.size() < DEPTH) mq.push_back({wr_last, wr_data});
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(tag, txd, exp_txd);
      chk("R8", dtr_n, exp_dtr);
    end
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n == 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got %0d cycles expected completion earlier", cyc_n);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic l);
    wr_valid = 1'b1; wr_data = d; wr_last = l;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic load(input logic [7:0] q[$]);
    foreach (q[k]) push(q[k], k == q.size() - 1);
  endtask

  task automatic drain(input string rq);
    int n = 0;
    while ((pend.size() != 0 || mq.size() != 0) && n < 5000) begin
      @(negedge clk); n++;
    end
    chk(rq, n < 5000, 1'b1);
    cyc(4);
  endtask

  task automatic send(input string rq, input logic [7:0] q[$]);
    tag = rq;
    tx_en = 1'b0; cyc(2);
    load(q);
    cyc(3);
    tx_en = 1'b1;
    drain(rq);
  endtask

  initial begin
    logic [7:0] ref9[$];
    bit saw0;
    // R1: reset state
    cyc(2);
    chk("R1", txd, 1'b1);
    chk("R1", dtr_n, 1'b1);
    cyc(2);
    rst = 1'b0;
    cmp_on = 1;

    // R4: check-sequence anchor value for the ASCII digits 1..9
    ref9 = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    total++;
    if (fcs16(ref9) != 16'h906E) begin
      bad++;
      $display("FAIL R4: got %h expected 906e", fcs16(ref9));
    end

    // R1: idle line while active with nothing queued
    tag = "R1"; tx_en = 1'b1; cyc(20);
    chk("R1", txd, 1'b1);

    send("R4", '{8'h11, 8'hA5, 8'h3C});
    send("R2", ref9);
    send("R3", '{8'hFF, 8'hFF, 8'h7E, 8'hF8});
    msb_first = 1'b1;
    send("R6", '{8'h01, 8'h80, 8'hF0, 8'h1F});
    msb_first = 1'b0;
    no_crc = 1'b1;
    send("R5", '{8'hF8});
    send("R5", '{8'h5A, 8'h3E});
    no_crc = 1'b0;
    pre_en = 1'b1; pre_pattern = 8'hA3; pre_count = 4'd3;
    send("R7", '{8'h42});
    msb_first = 1'b1;
    send("R7", '{8'h42, 8'h24});
    msb_first = 1'b0; pre_count = 4'd0;
    send("R7", '{8'h43});
    pre_en = 1'b0;

    // R2: two frames queued back to back
    tag = "R2"; tx_en = 1'b0; cyc(2);
    load('{8'hC3, 8'h18});
    load('{8'hE7});
    cyc(3); tx_en = 1'b1;
    drain("R2");

    // R8: terminal-ready follows its control bit
    tag = "R8";
    dtr_on = 1'b1; cyc(2); chk("R8", dtr_n, 1'b0);
    dtr_on = 1'b0; cyc(2); chk("R8", dtr_n, 1'b1);
    dtr_on = 1'b1; cyc(1);

    // R9: pause mid-frame with auto mode off, then resume
    tag = "R9"; auto_en = 1'b0; tx_en = 1'b0; cyc(2);
    load('{8'h12, 8'h34, 8'h56, 8'h78});
    cyc(3); tx_en = 1'b1; cyc(30);
    cts_n = 1'b1; cyc(12);
    chk("R9", txd, 1'b1);
    cts_n = 1'b0;
    drain("R9");

    // R10: flush mid-frame with auto mode on
    tag = "R10"; auto_en = 1'b1; tx_en = 1'b0; cyc(2);
    load('{8'h9A, 8'hBC, 8'hDE, 8'hF0});
    load('{8'h0F, 8'h33});
    cyc(3); tx_en = 1'b1; cyc(25);
    cts_n = 1'b1; cyc(3);
    chk("R10", wr_full, 1'b0);
    cts_n = 1'b0; cyc(120);
    chk("R10", txd, 1'b1);

    // R11: clear-to-send ignored while disabled, even in auto mode
    tag = "R11"; tx_en = 1'b0; cts_n = 1'b1; cyc(2);
    load('{8'h6D, 8'hB2});
    cyc(6);
    cts_n = 1'b0; cyc(2);
    tx_en = 1'b1;
    saw0 = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd == 1'b0) saw0 = 1;
    end
    chk("R11", saw0, 1'b1);
    drain("R11");
    auto_en = 1'b0;

    // R12: fill to depth, extra write dropped
    tag = "R12"; tx_en = 1'b0; cyc(2);
    for (int i = 0; i < DEPTH - 1; i++) push(8'(i * 37 + 5), 1'b0);
    push(8'hAA, 1'b1);
    chk("R12", wr_full, 1'b1);
    push(8'h55, 1'b1);
    chk("R12", wr_full, 1'b1);
    cyc(3); tx_en = 1'b1;
    drain("R12");
    chk("R12", wr_full, 1'b0);
    cyc(60);
    chk("R12", txd, 1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule